// File: doc/BRIEF.md
# Start-Stop Serial Receiver with Address-Frame Filter

This block takes characters from one asynchronous serial line. Each character is framed by a start bit and one or two stop bits. A free-running enable pulse at sixteen times the bit rate drives the sampling. The frame format is chosen by static inputs:

- seven or eight data bits, least significant bit first;
- an optional parity bit, even or odd;
- an optional address/data marker bit;
- one or two stop bits.

Each character is assembled in a shift stage and then moved to a holding register. The holding register stays valid until the consumer acknowledges it, and a character that arrives while it is still occupied is reported as an overrun. Parity, stop-bit and overrun faults are kept in sticky flags until they are cleared. A data-ready request and an error request come out on separate lines. The data-ready request is suited to driving a transfer engine.

For multi-drop links, the consumer can arm a wait state. While the wait state is armed, frames whose marker bit is 0 are thrown away silently. The first frame whose marker bit is 1 is kept, and it ends the wait. The line level is also available unfiltered, so that software can tell a break (a line held low) from a single bad stop bit.

Top module: `mpuart_rx`

## Requirements
- R1: After reset, rx_full, err_parity, err_frame, err_overrun, mp_wait, irq_rxfull and irq_rxerr are all 0.
- R2: A frame is a low start bit followed by the data bits, least significant first. Then come the parity bit (if cfg_par_en=1), the marker bit (if cfg_mp_en=1) and the stop bit(s). With cfg_len7=0, the 8 data bits appear on rx_data and rx_full and irq_rxfull go to 1.
- R3: With cfg_len7=1, seven data bits are received into rx_data[6:0], and rx_data[7] reads 0.
- R4: With cfg_par_en=1, the parity bit must make the count of ones over the data and parity bits even (cfg_par_odd=0) or odd (cfg_par_odd=1). A mismatch sets err_parity and irq_rxerr. The character is still stored.
- R5: A low level at the centre of the first stop bit sets err_frame and irq_rxerr. rxd_level always equals the present rxd level.
- R6: If a character completes while rx_full=1 and rd_ack is not asserted, err_overrun is set and rx_data keeps the older character.
- R7: A one-cycle rd_ack clears rx_full. Error flags stay set until a one-cycle clr_err clears them.
- R8: A start bit is accepted only if the line is still low at the eighth enable pulse after the falling edge is seen. A shorter low pulse produces no character.
- R9: With cfg_stop2=1, only the first stop bit is checked. A low second stop bit raises no framing error, and a low first stop bit does.
- R10: With cfg_mp_en=1 and the wait state armed by mp_wait_set, frames whose marker bit is 0 are discarded: no data, no flag. The first frame whose marker bit is 1 is stored, sets rx_mpb to 1 and clears mp_wait.
- R11: While rx_en=0, no character is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Enable pulse at 16 times the bit rate |
| rxd | input | 1 | Serial input line |
| rx_en | input | 1 | Receiver enable |
| cfg_len7 | input | 1 | 1 = seven data bits, 0 = eight |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| cfg_mp_en | input | 1 | Marker bit present |
| cfg_stop2 | input | 1 | Two stop bits |
| mp_wait_set | input | 1 | Pulse: arm the address-frame wait state |
| rd_ack | input | 1 | Pulse: holding register consumed |
| clr_err | input | 1 | Pulse: clear all error flags |
| rx_data | output | 8 | Holding register |
| rx_mpb | output | 1 | Marker bit of the held character |
| rx_full | output | 1 | Holding register valid |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |
| mp_wait | output | 1 | Wait state armed |
| irq_rxfull | output | 1 | Data-ready request |
| irq_rxerr | output | 1 | Error request |
| rxd_level | output | 1 | Unfiltered line level |

## Verification
A bit counter or state register off by one position shifts every later sample. It shows as a wrong rx_data value, or as a parity or framing flag set at the stop-bit centre of the same frame. A slip in the sample point within a bit shows only when stimulus edges fall close to a sample. So the glitch and back-to-back frame cases are aimed near the half-bit boundary. A wrong holding or wait state shows one frame later: a lost, overwritten or wrongly kept character, or a flag that appears or stays when it should not.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  localparam int DATA_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_MPB, ST_STOP, ST_STOP2
  } rx_state_t;

  // 1 when the received parity bit disagrees with the selected sense
  function automatic logic parity_bad(logic [DATA_W-1:0] d, logic len7,
                                      logic pbit, logic odd);
    logic [DATA_W-1:0] m;
    m = len7 ? {1'b0, d[DATA_W-2:0]} : d;
    return (^m) ^ pbit ^ odd;
  endfunction

  // state following the last data bit
  function automatic rx_state_t after_data(logic par_en, logic mp_en);
    if (par_en) return ST_PAR;
    if (mp_en)  return ST_MPB;
    return ST_STOP;
  endfunction
endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '1;
        else        sr <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sr <= '1;
        else        sr <= {sr[STAGES-2:0], d};
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/mpr_frame.sv
module mpr_frame
  import mpr_pkg::*;
#(
  parameter int OS_RATE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxs,
  input  logic              rx_en,
  input  logic              len7,
  input  logic              par_en,
  input  logic              mp_en,
  input  logic              stop2,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              pbit,
  output logic              mpbit,
  output logic              stop_ok
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam int HALF  = OS_RATE / 2;
  localparam int BIT_W = $clog2(DATA_W);

  rx_state_t        st;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitn;
  logic             centre;
  logic             last_bit;

  assign centre   = tick && (cnt == CNT_W'(OS_RATE - 1));
  assign last_bit = (bitn == (len7 ? BIT_W'(DATA_W - 2) : BIT_W'(DATA_W - 1)));
  assign done     = rx_en && centre && (st == ST_STOP);
  assign stop_ok  = rxs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      data  <= '0;
      pbit  <= 1'b0;
      mpbit <= 1'b0;
    end else if (!rx_en) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else if (tick) begin
      case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (!rxs) st <= ST_START;
        end
        ST_START: begin
          if (cnt == CNT_W'(HALF - 1)) begin
            cnt <= '0;
            if (!rxs) begin
              st    <= ST_DATA;
              bitn  <= '0;
              data  <= '0;
              pbit  <= 1'b0;
              mpbit <= 1'b0;
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          if (centre) begin
            cnt <= '0;
            case (st)
              ST_DATA: begin
                data[bitn] <= rxs;
                if (last_bit) st <= after_data(par_en, mp_en);
                else          bitn <= bitn + 1'b1;
              end
              ST_PAR: begin
                pbit <= rxs;
                st   <= mp_en ? ST_MPB : ST_STOP;
              end
              ST_MPB: begin
                mpbit <= rxs;
                st    <= ST_STOP;
              end
              ST_STOP:  st <= stop2 ? ST_STOP2 : ST_IDLE;
              default:  st <= ST_IDLE;
            endcase
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mpr_hold.sv
module mpr_hold
  import mpr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] data,
  input  logic              pbit,
  input  logic              mpbit,
  input  logic              stop_ok,
  input  logic              len7,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              mp_en,
  input  logic              mp_wait_set,
  input  logic              rd_ack,
  input  logic              clr_err,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_mpb,
  output logic              rx_full,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              mp_wait,
  output logic              ev_store,
  output logic              ev_drop,
  output logic              ev_overrun
);
  logic waiting, accept, busy;

  assign waiting    = mp_wait && mp_en;
  assign ev_drop    = done && waiting && !mpbit;
  assign accept     = done && !ev_drop;
  assign busy       = rx_full && !rd_ack;
  assign ev_overrun = accept && busy;
  assign ev_store   = accept && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data     <= '0;
      rx_mpb      <= 1'b0;
      rx_full     <= 1'b0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
      mp_wait     <= 1'b0;
    end else begin
      if (ev_store) begin
        rx_data <= data;
        rx_mpb  <= mp_en && mpbit;
        rx_full <= 1'b1;
      end else if (rd_ack) begin
        rx_full <= 1'b0;
      end

      if (clr_err) begin
        err_parity  <= 1'b0;
        err_frame   <= 1'b0;
        err_overrun <= 1'b0;
      end
      if (ev_store && par_en && parity_bad(data, len7, pbit, par_odd))
        err_parity <= 1'b1;
      if (ev_store && !stop_ok)
        err_frame <= 1'b1;
      if (ev_overrun)
        err_overrun <= 1'b1;

      if (mp_wait_set)
        mp_wait <= 1'b1;
      else if (ev_store && waiting)
        mp_wait <= 1'b0;
    end
  end
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx
  import mpr_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              rx_en,
  input  logic              cfg_len7,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_mp_en,
  input  logic              cfg_stop2,
  input  logic              mp_wait_set,
  input  logic              rd_ack,
  input  logic              clr_err,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_mpb,
  output logic              rx_full,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              mp_wait,
  output logic              irq_rxfull,
  output logic              irq_rxerr,
  output logic              rxd_level
);
  logic              rxs;
  logic              ev_done;
  logic [DATA_W-1:0] sh_data;
  logic              sh_pbit, sh_mpbit, sh_stop_ok;
  logic              ev_store, ev_drop, ev_overrun;

  mpr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxs)
  );

  mpr_frame #(.OS_RATE(OS_RATE)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rxs(rxs), .rx_en(rx_en),
    .len7(cfg_len7), .par_en(cfg_par_en), .mp_en(cfg_mp_en), .stop2(cfg_stop2),
    .done(ev_done), .data(sh_data), .pbit(sh_pbit), .mpbit(sh_mpbit),
    .stop_ok(sh_stop_ok)
  );

  mpr_hold u_hold (
    .clk(clk), .rst_n(rst_n), .done(ev_done), .data(sh_data), .pbit(sh_pbit),
    .mpbit(sh_mpbit), .stop_ok(sh_stop_ok), .len7(cfg_len7),
    .par_en(cfg_par_en), .par_odd(cfg_par_odd), .mp_en(cfg_mp_en),
    .mp_wait_set(mp_wait_set), .rd_ack(rd_ack), .clr_err(clr_err),
    .rx_data(rx_data), .rx_mpb(rx_mpb), .rx_full(rx_full),
    .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun),
    .mp_wait(mp_wait), .ev_store(ev_store), .ev_drop(ev_drop),
    .ev_overrun(ev_overrun)
  );

  assign irq_rxfull = rx_full;
  assign irq_rxerr  = err_parity | err_frame | err_overrun;
  assign rxd_level  = rxd;
endmodule

// File: rtl/mpuart_rx_chk.sv
module mpuart_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_en,
  input logic       rd_ack,
  input logic       clr_err,
  input logic [7:0] rx_data,
  input logic       rx_full,
  input logic       err_parity,
  input logic       err_frame,
  input logic       err_overrun,
  input logic       mp_wait,
  input logic       ev_done,
  input logic       ev_store,
  input logic       ev_drop,
  input logic       ev_overrun
);
  assert_full_from_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_full) |-> $past(ev_store));

  assert_hold_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rd_ack) |=> $stable(rx_data));

  assert_overrun_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_overrun |=> err_overrun);

  assert_frame_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frame && !clr_err) |=> err_frame);

  assert_parity_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (err_parity && !clr_err) |=> err_parity);

  assert_drop_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> ($stable(rx_data) && !$rose(err_parity) && !$rose(err_frame)
                 && !$rose(err_overrun)));

  assert_wait_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mp_wait) |-> $past(ev_store));

  assert_disabled_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !ev_done);
endmodule

bind mpuart_rx mpuart_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rd_ack(rd_ack), .clr_err(clr_err),
  .rx_data(rx_data), .rx_full(rx_full), .err_parity(err_parity),
  .err_frame(err_frame), .err_overrun(err_overrun), .mp_wait(mp_wait),
  .ev_done(ev_done), .ev_store(ev_store), .ev_drop(ev_drop),
  .ev_overrun(ev_overrun)
);

// File: tb/mpuart_rx_bench.sv
module mpuart_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic os_tick;
  logic rxd = 1'b1;
  logic rx_en = 1'b1;
  logic cfg_len7 = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic cfg_mp_en = 1'b0, cfg_stop2 = 1'b0;
  logic mp_wait_set = 1'b0, rd_ack = 1'b0, clr_err = 1'b0;
  logic [7:0] rx_data;
  logic rx_mpb, rx_full, err_parity, err_frame, err_overrun, mp_wait;
  logic irq_rxfull, irq_rxerr, rxd_level;
  logic [1:0] tdiv = 2'd0;
  int nvec = 0, nfail = 0;

  always #5 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign os_tick = (tdiv == 2'd3);

  mpuart_rx u_mpuart_rx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd), .rx_en(rx_en),
    .cfg_len7(cfg_len7), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_mp_en(cfg_mp_en), .cfg_stop2(cfg_stop2), .mp_wait_set(mp_wait_set),
    .rd_ack(rd_ack), .clr_err(clr_err), .rx_data(rx_data), .rx_mpb(rx_mpb),
    .rx_full(rx_full), .err_parity(err_parity), .err_frame(err_frame),
    .err_overrun(err_overrun), .mp_wait(mp_wait), .irq_rxfull(irq_rxfull),
    .irq_rxerr(irq_rxerr), .rxd_level(rxd_level)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bit slot = 16 enable pulses = 64 clocks
  task automatic bit_out(input logic v);
    rxd = v;
    repeat (64) @(negedge clk);
  endtask

  task automatic idle(input int n);
    rxd = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input logic l7, input logic pe,
                      input logic po, input logic pflip, input logic me,
                      input logic mb, input logic s1, input logic s2en,
                      input logic s2);
    logic [7:0] m;
    logic p;
    cfg_len7 = l7; cfg_par_en = pe; cfg_par_odd = po;
    cfg_mp_en = me; cfg_stop2 = s2en;
    m = l7 ? {1'b0, d[6:0]} : d;
    p = ($countones(m) % 2 == 1) ^ po ^ pflip;
    bit_out(1'b0);
    for (int i = 0; i < (l7 ? 7 : 8); i++) bit_out(d[i]);
    if (pe) bit_out(p);
    if (me) bit_out(mb);
    bit_out(s1);
    if (s2en) bit_out(s2);
    idle(20);
  endtask

  task automatic flush();
    idle(1500);
    pulse(rd_ack);
    pulse(clr_err);
    idle(10);
  endtask

  task automatic t_reset();
    chk("R1 rx_full", rx_full, 0);
    chk("R1 errors", {err_parity, err_frame, err_overrun}, 0);
    chk("R1 mp_wait", mp_wait, 0);
    chk("R1 irqs", {irq_rxfull, irq_rxerr}, 0);
  endtask

  task automatic t_basic8();
    send(8'hA5, 0, 0, 0, 0, 0, 0, 1, 0, 1);
    chk("R2 data", rx_data, 8'hA5);
    chk("R2 full/irq", {rx_full, irq_rxfull, irq_rxerr}, 3'b110);
    pulse(rd_ack);
    chk("R7 rd_ack clears full", rx_full, 0);
    send(8'h3C, 0, 0, 0, 0, 0, 0, 1, 0, 1);
    chk("R2 second data", rx_data, 8'h3C);
    pulse(rd_ack);
  endtask

  task automatic t_len7();
    send(8'hD6, 1, 0, 0, 0, 0, 0, 1, 0, 1);
    chk("R3 seven bit data", rx_data, 8'h56);
    chk("R3 no error", irq_rxerr, 0);
    pulse(rd_ack);
  endtask

  task automatic t_parity();
    send(8'h71, 0, 1, 0, 0, 0, 0, 1, 0, 1);
    chk("R4 even good", {err_parity, rx_data}, {1'b0, 8'h71});
    pulse(rd_ack);
    send(8'h71, 0, 1, 1, 0, 0, 0, 1, 0, 1);
    chk("R4 odd good", err_parity, 0);
    pulse(rd_ack);
    send(8'h2B, 1, 1, 1, 1, 0, 0, 1, 0, 1);
    chk("R4 odd mismatch", {err_parity, irq_rxerr}, 2'b11);
    chk("R4 data kept", {rx_full, rx_data}, {1'b1, 8'h2B});
    pulse(rd_ack);
    idle(100);
    chk("R7 parity sticky", err_parity, 1);
    pulse(clr_err);
    chk("R7 clr_err", irq_rxerr, 0);
  endtask

  task automatic t_framing();
    cfg_len7 = 0; cfg_par_en = 0; cfg_mp_en = 0; cfg_stop2 = 0;
    bit_out(1'b0);
    for (int i = 0; i < 9; i++) bit_out(1'b0);
    rxd = 1'b0;
    repeat (20) @(negedge clk);
    chk("R5 framing error", {err_frame, irq_rxerr}, 2'b11);
    chk("R5 break level", rxd_level, 0);
    chk("R5 break data", rx_data, 8'h00);
    flush();
    chk("R5 line high level", rxd_level, 1);
  endtask

  task automatic t_overrun();
    send(8'h11, 0, 0, 0, 0, 0, 0, 1, 0, 1);
    send(8'h99, 0, 0, 0, 0, 0, 0, 1, 0, 1);
    chk("R6 overrun flag", {err_overrun, irq_rxerr}, 2'b11);
    chk("R6 old data kept", rx_data, 8'h11);
    pulse(rd_ack);
    pulse(clr_err);
  endtask

  task automatic t_glitch();
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    idle(900);
    chk("R8 short low ignored", {rx_full, irq_rxerr}, 2'b00);
  endtask

  task automatic t_stop2();
    send(8'h5A, 0, 0, 0, 0, 0, 0, 1, 1, 0);
    chk("R9 second stop unchecked", {err_frame, rx_data}, {1'b0, 8'h5A});
    flush();
    send(8'h5A, 0, 0, 0, 0, 0, 0, 0, 1, 1);
    chk("R9 first stop checked", err_frame, 1);
    flush();
  endtask

  task automatic t_mpfilter();
    cfg_mp_en = 1'b1;
    pulse(mp_wait_set);
    chk("R10 wait armed", mp_wait, 1);
    send(8'h11, 0, 0, 0, 0, 1, 0, 0, 0, 1);
    chk("R10 data frame dropped", {rx_full, irq_rxerr, mp_wait}, 3'b001);
    send(8'h42, 0, 0, 0, 0, 1, 1, 1, 0, 1);
    chk("R10 id frame stored", {rx_full, rx_mpb, rx_data}, {2'b11, 8'h42});
    chk("R10 wait cleared", mp_wait, 0);
    pulse(rd_ack);
    send(8'h33, 0, 0, 0, 0, 1, 0, 1, 0, 1);
    chk("R10 data after id", {rx_full, rx_mpb, rx_data}, {2'b10, 8'h33});
    pulse(rd_ack);
  endtask

  task automatic t_disabled();
    rx_en = 1'b0;
    send(8'hE7, 0, 0, 0, 0, 0, 0, 1, 0, 1);
    chk("R11 disabled no data", rx_full, 0);
    rx_en = 1'b1;
    idle(10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    idle(100);
    t_basic8();
    t_len7();
    t_parity();
    t_framing();
    t_overrun();
    t_glitch();
    t_stop2();
    t_mpfilter();
    t_disabled();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule